// File: doc/BRIEF.md
# Programmable Product-Term Logic Block

This block is a configurable sum-of-products array of sixteen macrocells. All macrocells share a bank of 36 global input signals. Each macrocell builds five product terms from a programmable AND plane and ORs them into one result. A register follows the OR, and a configuration bit can bypass it. Each macrocell also builds one pool product term from the global inputs. The inverse of every pool term is fed back into the AND plane, so any macrocell can use it as an extra literal.

Product terms can also be lent down a one-way expander chain, from macrocell n to macrocell n+1. A macrocell can pass the chain it receives onward, so a single macrocell can collect terms from several macrocells above it. The register selects its clock tick, clock enable, asynchronous clear and asynchronous preset independently.

All configuration is loaded one bit per clock through a serial shift chain. It stays static while the block runs. Every output is held at zero until a complete load has finished.

Top module: `prog_lab`

## Requirements
- R1: While `cfgLoad` is high, each rising clock edge shifts in one bit from `cfgBit`. After exactly 9648 shifts, the first bit shifted in sits at configuration bit 0. `mcOut` is zero during the load. A load of the full length takes effect at the first rising edge after `cfgLoad` falls.
- R2: A load of fewer than 9648 bits, or no load at all, leaves every `mcOut` bit at zero.
- R3: Macrocell n owns configuration bits n*603 to n*603+602:
  - five product terms of 104 bits each, at offsets 0, 104, 208, 312 and 416;
  - the pool term at offset 520;
  - lend mask at 592..596, one bit per own term;
  - forward at 597, bypass at 598, clock select at 599;
  - enable-use at 600, clear-use at 601, preset-use at 602.
- R4: In a product term, bit j selects signal j in true form and bit 52+j selects it in complement form. Signal j is `dataIn[j]` for j<36 and the inverted pool term of macrocell j-36 otherwise. The term is the AND of its selected literals, and it is 0 when nothing is selected.
- R5: A pool term has 72 bits: bit i selects `dataIn[i]` true and bit 36+i selects it complemented. Selection follows the rule of R4. Its inverse is visible to all sixteen macrocells.
- R6: The OR result of a macrocell is the OR of its own terms whose lend bit is clear, together with the incoming chain value when forward is 0. A lent term never reaches its own macrocell's OR.
- R7: The chain leaving macrocell n is the OR of its lent terms, together with the incoming chain value when forward is 1. Macrocell 0 receives 0, and the chain out of macrocell 15 goes nowhere.
- R8: With bypass set, `mcOut[n]` follows the OR result in the same cycle, with no clock.
- R9: With bypass clear, the register captures the OR result at a rising edge only when both of these hold:
  - the selected tick is high (`tickA` when clock select is 0, `tickB` when it is 1);
  - enable-use is 0 or `gEn` is high.
  Otherwise the register holds its value.
- R10: With clear-use set, `clrIn` high forces the register to 0 at once. With preset-use set, `preIn` forces it to 1. When both are active, clear wins.
- R11: `rstN` low clears every register, invalidates the configuration and forces `mcOut` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgLoad | input | 1 | Serial configuration load enable |
| cfgBit | input | 1 | Serial configuration data |
| dataIn | input | 36 | Global input signals to the AND plane |
| tickA | input | 1 | First register tick strobe |
| tickB | input | 1 | Second register tick strobe |
| gEn | input | 1 | Global clock enable |
| clrIn | input | 1 | Global asynchronous clear request |
| preIn | input | 1 | Global asynchronous preset request |
| mcOut | output | 16 | Macrocell outputs |

## Verification
Results arrive on three timescales:
- Bypassed outputs and asynchronous clear or preset settle within the same cycle. The bench drives inputs on the falling edge and compares one time unit later.
- A registered output shows the OR result captured at the next rising edge. The bench's model advances its register copies only after that edge and compares at the following falling edge.
- A new configuration becomes valid one rising edge after `cfgLoad` drops. The bench lets that edge pass before its first comparison of a loaded configuration.

// File: rtl/lab_pkg.sv
package lab_pkg;

  typedef struct packed {
    logic shiftEn;
    logic holdRegs;
    logic cfgValid;
  } labStrobes_t;

  // one macrocell record: terms, pool term, lend mask, forward and five register options
  function automatic int cfgRecordWidth(int nIn, int nMc, int nPt);
    return nPt * 2 * (nIn + nMc) + 2 * nIn + nPt + 6;
  endfunction

endpackage

// File: rtl/lab_ctrl.sv
module lab_ctrl
  import lab_pkg::*;
#(
  parameter int CFG_W = 9648
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgLoad,
  output labStrobes_t strobes
);

  localparam int CNT_W = $clog2(CFG_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CFG_W);

  logic [CNT_W-1:0] shiftCount;
  logic             loadPrev;
  logic             validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftCount <= '0;
      loadPrev   <= 1'b0;
      validQ     <= 1'b0;
    end else begin
      loadPrev <= cfgLoad;
      if (cfgLoad) begin
        validQ <= 1'b0;
        if (!loadPrev)
          shiftCount <= CNT_W'(1);
        else if (shiftCount != FULL)
          shiftCount <= shiftCount + 1'b1;
      end else begin
        validQ <= (shiftCount == FULL);
      end
    end
  end

  assign strobes = '{shiftEn: cfgLoad, holdRegs: !validQ, cfgValid: validQ};

  // R1: a load in progress always invalidates the configuration
  a_r1_load_invalidates: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> !validQ);

  // R2: validity only ever follows a full-length load
  a_r2_valid_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validQ) |-> ($past(shiftCount) == FULL));

endmodule

// File: rtl/lab_macrocell.sv
module lab_macrocell
  import lab_pkg::*;
#(
  parameter int NUM_IN    = 36,
  parameter int NUM_MC    = 16,
  parameter int PT_PER_MC = 5,
  parameter int MC_W      = cfgRecordWidth(NUM_IN, NUM_MC, PT_PER_MC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdRegs,
  input  logic              cfgValid,
  input  logic [MC_W-1:0]   cfgRec,
  input  logic [NUM_IN-1:0] dataIn,
  input  logic [NUM_MC-1:0] poolInv,
  input  logic              chainIn,
  input  logic              tickA,
  input  logic              tickB,
  input  logic              gEn,
  input  logic              clrIn,
  input  logic              preIn,
  output logic              poolTerm,
  output logic              chainOut,
  output logic              mcOut
);

  localparam int NUM_SIG  = NUM_IN + NUM_MC;
  localparam int TERM_W   = 2 * NUM_SIG;
  localparam int POOL_W   = 2 * NUM_IN;
  localparam int POOL_OFS = PT_PER_MC * TERM_W;
  localparam int LEND_OFS = POOL_OFS + POOL_W;
  localparam int FWD_OFS  = LEND_OFS + PT_PER_MC;
  localparam int BYP_OFS  = FWD_OFS + 1;
  localparam int CLK_OFS  = BYP_OFS + 1;
  localparam int CE_OFS   = CLK_OFS + 1;
  localparam int CLR_OFS  = CE_OFS + 1;
  localparam int PRE_OFS  = CLR_OFS + 1;

  logic [NUM_SIG-1:0]   sigVec;
  logic [PT_PER_MC-1:0] termVal;
  logic [PT_PER_MC-1:0] lendMask;
  logic [POOL_W-1:0]    poolSel;
  logic                 forwardEn;
  logic                 orSum;
  logic                 captureEn;
  logic                 clrNet;
  logic                 preNet;
  logic                 regQ;

  assign sigVec = {poolInv, dataIn};

  for (genvar k = 0; k < PT_PER_MC; k++) begin : g_term
    logic [TERM_W-1:0] sel;
    assign sel = cfgRec[k*TERM_W +: TERM_W];
    assign termVal[k] = (|sel)
                      & (&(~sel[NUM_SIG-1:0] | sigVec))
                      & (&(~sel[TERM_W-1:NUM_SIG] | ~sigVec));
  end

  assign poolSel  = cfgRec[POOL_OFS +: POOL_W];
  assign poolTerm = (|poolSel)
                  & (&(~poolSel[NUM_IN-1:0] | dataIn))
                  & (&(~poolSel[POOL_W-1:NUM_IN] | ~dataIn));

  assign lendMask  = cfgRec[LEND_OFS +: PT_PER_MC];
  assign forwardEn = cfgRec[FWD_OFS];

  assign orSum    = (|(termVal & ~lendMask)) | (chainIn & ~forwardEn);
  assign chainOut = (|(termVal & lendMask)) | (chainIn & forwardEn);

  assign captureEn = (cfgRec[CLK_OFS] ? tickB : tickA) & (~cfgRec[CE_OFS] | gEn);
  assign clrNet    = cfgValid & cfgRec[CLR_OFS] & clrIn;
  assign preNet    = cfgValid & cfgRec[PRE_OFS] & preIn;

  always_ff @(posedge clk or negedge rstN or posedge clrNet or posedge preNet) begin
    if (!rstN)          regQ <= 1'b0;
    else if (clrNet)    regQ <= 1'b0;
    else if (preNet)    regQ <= 1'b1;
    else if (holdRegs)  regQ <= 1'b0;
    else if (captureEn) regQ <= orSum;
  end

  assign mcOut = cfgValid & (cfgRec[BYP_OFS] ? orSum : regQ);

  // R10: an active clear holds the register low, even against preset
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    clrNet |-> !regQ);

  // R10: a fresh preset without any clear sets the register
  a_r10_preset_sets: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(preNet) && !clrNet && !$past(clrNet)) |-> regQ);

  // R9: an enabled tick captures the OR result
  a_r9_capture: assert property (@(posedge clk) disable iff (!rstN || clrNet || preNet)
    (captureEn && !holdRegs) |=> (regQ == $past(orSum)));

endmodule

// File: rtl/lab_datapath.sv
module lab_datapath
  import lab_pkg::*;
#(
  parameter int NUM_IN    = 36,
  parameter int NUM_MC    = 16,
  parameter int PT_PER_MC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  labStrobes_t       strobes,
  input  logic              cfgBit,
  input  logic [NUM_IN-1:0] dataIn,
  input  logic              tickA,
  input  logic              tickB,
  input  logic              gEn,
  input  logic              clrIn,
  input  logic              preIn,
  output logic [NUM_MC-1:0] mcOut
);

  localparam int MC_W  = cfgRecordWidth(NUM_IN, NUM_MC, PT_PER_MC);
  localparam int CFG_W = NUM_MC * MC_W;

  logic [CFG_W-1:0]  cfgReg;
  logic [NUM_MC-1:0] poolTerm;
  logic [NUM_MC-1:0] poolInv;
  logic [NUM_MC:0]   chainNet;
  logic              chainUnused;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cfgReg <= '0;
    else if (strobes.shiftEn) cfgReg <= {cfgBit, cfgReg[CFG_W-1:1]};
  end

  assign poolInv     = ~poolTerm;
  assign chainNet[0] = 1'b0;
  assign chainUnused = chainNet[NUM_MC];

  for (genvar n = 0; n < NUM_MC; n++) begin : g_mc
    lab_macrocell #(
      .NUM_IN   (NUM_IN),
      .NUM_MC   (NUM_MC),
      .PT_PER_MC(PT_PER_MC),
      .MC_W     (MC_W)
    ) u_mc (
      .clk     (clk),
      .rstN    (rstN),
      .holdRegs(strobes.holdRegs),
      .cfgValid(strobes.cfgValid),
      .cfgRec  (cfgReg[n*MC_W +: MC_W]),
      .dataIn  (dataIn),
      .poolInv (poolInv),
      .chainIn (chainNet[n]),
      .tickA   (tickA),
      .tickB   (tickB),
      .gEn     (gEn),
      .clrIn   (clrIn),
      .preIn   (preIn),
      .poolTerm(poolTerm[n]),
      .chainOut(chainNet[n+1]),
      .mcOut   (mcOut[n])
    );
  end

  // R11: a reset or an invalid configuration keeps every output low
  a_r11_invalid_quiet: assert property (@(posedge clk)
    !strobes.cfgValid |-> (mcOut == '0));

endmodule

// File: rtl/prog_lab.sv
module prog_lab
  import lab_pkg::*;
#(
  parameter int NUM_IN    = 36,
  parameter int NUM_MC    = 16,
  parameter int PT_PER_MC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic              cfgBit,
  input  logic [NUM_IN-1:0] dataIn,
  input  logic              tickA,
  input  logic              tickB,
  input  logic              gEn,
  input  logic              clrIn,
  input  logic              preIn,
  output logic [NUM_MC-1:0] mcOut
);

  localparam int CFG_W = NUM_MC * cfgRecordWidth(NUM_IN, NUM_MC, PT_PER_MC);

  labStrobes_t strobes;

  lab_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgLoad(cfgLoad),
    .strobes(strobes)
  );

  lab_datapath #(
    .NUM_IN   (NUM_IN),
    .NUM_MC   (NUM_MC),
    .PT_PER_MC(PT_PER_MC)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .cfgBit (cfgBit),
    .dataIn (dataIn),
    .tickA  (tickA),
    .tickB  (tickB),
    .gEn    (gEn),
    .clrIn  (clrIn),
    .preIn  (preIn),
    .mcOut  (mcOut)
  );

endmodule

// File: tb/prog_lab_tb.sv
module prog_lab_tb;

  localparam int NMC = 16, NIN = 36, NPT = 5, NSIG = 52, TW = 104;
  localparam int MCW = 603, CFGW = 9648;
  localparam int POOLO = 520, LENDO = 592, FWDO = 597, BYPO = 598;
  localparam int CLKO = 599, CEO = 600, CLRO = 601, PREO = 602;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0, cfgBit = 1'b0;
  logic [NIN-1:0] din = '0;
  logic tA = 1'b0, tB = 1'b0, gE = 1'b0, cI = 1'b0, pI = 1'b0;
  logic [NMC-1:0] mcOut;

  logic [CFGW-1:0] cfgVec;
  bit qModel [NMC];
  bit orModel [NMC];
  bit poolModel [NMC];
  bit cfgOk = 1'b0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  prog_lab u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgBit(cfgBit), .dataIn(din),
    .tickA(tA), .tickB(tB), .gEn(gE), .clrIn(cI), .preIn(pI), .mcOut(mcOut)
  );

  function automatic bit cb(int n, int ofs);
    return cfgVec[n*MCW + ofs];
  endfunction

  // R5: pool term over dataIn only
  function automatic bit poolEval(int n);
    bit any = 0, v = 1;
    for (int i = 0; i < NIN; i++) begin
      bit t = cb(n, POOLO + i), c = cb(n, POOLO + NIN + i);
      if (t || c) any = 1;
      if (t && !din[i]) v = 0;
      if (c && din[i]) v = 0;
    end
    return any && v;
  endfunction

  // R4: product term over dataIn and inverted pool terms
  function automatic bit termEval(int n, int k);
    bit any = 0, v = 1;
    for (int j = 0; j < NSIG; j++) begin
      bit s = (j < NIN) ? din[j] : !poolModel[j-NIN];
      bit t = cb(n, k*TW + j), c = cb(n, k*TW + NSIG + j);
      if (t || c) any = 1;
      if (t && !s) v = 0;
      if (c && s) v = 0;
    end
    return any && v;
  endfunction

  // R6, R7: OR results and the one-way lending chain
  task automatic evalModel();
    bit chain = 0;
    for (int n = 0; n < NMC; n++) poolModel[n] = poolEval(n);
    for (int n = 0; n < NMC; n++) begin
      bit own = 0, lent = 0, fwd;
      for (int k = 0; k < NPT; k++) begin
        bit tv = termEval(n, k);
        if (cb(n, LENDO + k)) lent |= tv; else own |= tv;
      end
      fwd = cb(n, FWDO);
      orModel[n] = own | (fwd ? 1'b0 : chain);
      chain = lent | (fwd ? chain : 1'b0);
    end
  endtask

  task automatic chk(string tag, int n, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s mc%0d actual %0b expected %0b", tag, n, act, exp);
    end
  endtask

  task automatic checkZero(string tag);
    for (int n = 0; n < NMC; n++) chk(tag, n, mcOut[n], 1'b0);
  endtask

  // drive at the falling edge, compare 1 time unit later, then advance the model at the rising edge
  task automatic step(string tag);
    if (cfgOk)
      for (int n = 0; n < NMC; n++) begin
        if (cb(n, CLRO) && cI) qModel[n] = 0;
        else if (cb(n, PREO) && pI) qModel[n] = 1;
      end
    evalModel();
    #1;
    for (int n = 0; n < NMC; n++)
      chk(cb(n, BYPO) ? {tag, " R8"} : {tag, " R9"}, n, mcOut[n],
          cfgOk ? (cb(n, BYPO) ? orModel[n] : qModel[n]) : 1'b0);
    @(posedge clk);
    if (cfgOk)
      for (int n = 0; n < NMC; n++) begin
        bit cap = (cb(n, CLKO) ? tB : tA) && (!cb(n, CEO) || gE);
        if (cb(n, CLRO) && cI) qModel[n] = 0;
        else if (cb(n, PREO) && pI) qModel[n] = 1;
        else if (cap) qModel[n] = orModel[n];
      end
    @(negedge clk);
  endtask

  // R1: serial load, first bit ends at configuration bit 0
  task automatic loadCfg(int nbits);
    tA = 0; tB = 0; gE = 0; cI = 0; pI = 0;
    cfgLoad = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      cfgBit = cfgVec[i];
      @(posedge clk);
      @(negedge clk);
      if (i == nbits / 2) checkZero("R1 during load");
    end
    cfgLoad = 1'b0;
    cfgBit  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cfgOk = (nbits == CFGW);
    for (int n = 0; n < NMC; n++) qModel[n] = 0;
  endtask

  task automatic setLit(int n, int k, int j, bit comp);
    cfgVec[n*MCW + k*TW + (comp ? NSIG : 0) + j] = 1'b1;
  endtask

  task automatic genRandomCfg();
    cfgVec = '0;
    for (int n = 0; n < NMC; n++) begin
      for (int k = 0; k < NPT; k++)
        if ($urandom_range(0, 3) != 0) begin
          int lits = $urandom_range(1, 3);
          for (int l = 0; l < lits; l++) begin
            int j = ($urandom_range(0, 3) == 0) ? NIN + $urandom_range(0, NMC-1)
                                                : $urandom_range(0, NIN-1);
            setLit(n, k, j, 1'($urandom_range(0, 1)));
          end
        end
      for (int l = 0; l < 2; l++)
        cfgVec[n*MCW + POOLO + $urandom_range(0, 2*NIN-1)] = 1'b1;
      for (int k = 0; k < NPT; k++)
        cfgVec[n*MCW + LENDO + k] = ($urandom_range(0, 3) == 0);
      cfgVec[n*MCW + FWDO] = ($urandom_range(0, 3) == 0);
      for (int b = BYPO; b <= PREO; b++) cfgVec[n*MCW + b] = 1'($urandom_range(0, 1));
    end
  endtask

  task automatic randomSteps(int count, string tag);
    for (int s = 0; s < count; s++) begin
      din = {4'($urandom()), $urandom()};
      tA = 1'($urandom()); tB = 1'($urandom()); gE = 1'($urandom());
      step(tag);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    cfgVec = '0;
    #2;
    checkZero("R11 reset state");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R2: nothing loaded, then a short load
    din = '1;
    step("R2 unloaded");
    genRandomCfg();
    loadCfg(100);
    randomSteps(4, "R2 partial load");

    // random configurations
    for (int c = 0; c < 4; c++) begin
      genRandomCfg();
      loadCfg(CFGW);
      randomSteps(60, "R3 R4 R5 R6 R7");
    end

    // R7: chain mc0 -> mc1 (forward) -> mc2; R6 lent term leaves mc0
    cfgVec = '0;
    setLit(0, 0, 0, 1'b0);
    cfgVec[LENDO] = 1'b1;
    cfgVec[MCW + FWDO] = 1'b1;
    for (int n = 0; n < NMC; n++) cfgVec[n*MCW + BYPO] = 1'b1;
    loadCfg(CFGW);
    for (int v = 0; v < 2; v++) begin
      din = '0; din[0] = 1'(v);
      step("R6 R7 chain");
      chk("R7 chain end", 2, mcOut[2], 1'(v));
      chk("R6 lender", 0, mcOut[0], 1'b0);
    end

    // R5: pool term of mc5 = dataIn[1], used inverted by mc3 and mc4
    cfgVec = '0;
    cfgVec[5*MCW + POOLO + 1] = 1'b1;
    setLit(3, 0, NIN + 5, 1'b0);
    setLit(4, 2, NIN + 5, 1'b1);
    for (int n = 0; n < NMC; n++) cfgVec[n*MCW + BYPO] = 1'b1;
    loadCfg(CFGW);
    for (int v = 0; v < 2; v++) begin
      din = '0; din[1] = 1'(v);
      step("R5 shared pool");
      chk("R5 inverted use", 3, mcOut[3], !v);
      chk("R5 true use", 4, mcOut[4], 1'(v));
    end

    // R10: asynchronous preset and clear on registered cells
    cfgVec = '0;
    for (int n = 0; n < NMC; n++) begin
      setLit(n, 0, 2, 1'b0);
      cfgVec[n*MCW + CLRO] = 1'b1;
      cfgVec[n*MCW + PREO] = 1'b1;
    end
    loadCfg(CFGW);
    din = '0;
    pI = 1; step("R10 preset");
    chk("R10 preset", 7, mcOut[7], 1'b1);
    pI = 0; step("R10 preset released");
    cI = 1; step("R10 clear");
    chk("R10 clear", 7, mcOut[7], 1'b0);
    cI = 0; step("R10 clear released");
    cI = 1; pI = 1; step("R10 both");
    chk("R10 clear wins", 9, mcOut[9], 1'b0);
    cI = 0; pI = 0; step("R10 both released");
    din[2] = 1; tA = 1; step("R9 capture");
    step("R9 captured");
    chk("R9 captured", 0, mcOut[0], 1'b1);
    tA = 0; din[2] = 0; step("R9 hold");
    chk("R9 hold", 0, mcOut[0], 1'b1);

    // R11: reset mid-run invalidates the configuration
    rstN = 1'b0;
    #1;
    checkZero("R11 reset");
    @(negedge clk);
    rstN = 1'b1;
    cfgOk = 1'b0;
    for (int n = 0; n < NMC; n++) qModel[n] = 0;
    din = '1; tA = 1;
    step("R11 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule